// File: doc/BRIEF.md
# Bus Slave Address Window Translator

This block sits behind the address phase of a bus slave port. Each incoming access brings an address, an address-space code and a valid strobe. The block checks the access against four programmable windows. When a window claims it, the block returns the window index and a local address, which is the incoming address plus that window's translation offset. A fixed 4 KB configuration region at a programmable base is decoded in parallel and takes priority over every window. When neither a window nor the configuration region claims the access, a miss is reported so that the slave stays silent.

Each window has its own small state machine with two states. **OPEN** is the reset state: the window is disabled and its base, bound, offset and space fields can be written. **LOCKED** means the window is enabled and its attributes are frozen. A control write with the enable bit set moves OPEN to LOCKED (transition *arm*). A control write with the enable bit clear moves LOCKED to OPEN (transition *disarm*). Any other write leaves the state unchanged. Window 0 compares addresses on 4 KB pages. Windows 1 to 3 compare on 64 KB pages. The decode result is registered, so it appears one clock after the strobe.

Top module: `slv_win_xlate`

## Requirements
- R1: After reset, every window is in OPEN (disabled), the configuration base is 0, and out_vld, out_hit and out_cfg are 0.
- R2: Window 0 ignores address bits [11:0] when comparing base and bound, so a written bound of 0x000A_0800 acts as 0x000A_0000.
- R3: Windows 1 to 3 ignore address bits [15:0] when comparing base and bound, so a written base of 0x000A_8000 acts as 0x000A_0000.
- R4: in_spc and the window space field use the codes 0 = 16-bit, 1 = 24-bit, 2 = 32-bit and 3 = reserved. A window hits only when in_spc equals its space field. Code 3 never produces a window hit or a configuration hit.
- R5: A window hits when the page of in_addr is at or above its base page and strictly below its bound page. A window whose bound is at or below its base never hits.
- R6: On a window hit, out_addr equals in_addr plus the window's full 32-bit offset, modulo 2^32.
- R7: When several LOCKED windows hit, out_win reports the lowest-numbered one, and out_addr uses that window's offset.
- R8: A 32-bit-space access whose address bits [31:12] equal those of the configuration base gives out_cfg=1 and out_hit=0, even when a window also covers that address. out_addr is then in_addr[11:0], zero-extended. Accesses in the other address spaces never hit the configuration region.
- R9: While a window is LOCKED, writes to its base, bound, offset or space fields have no effect. After a disarm, the same writes take effect.
- R10: out_vld, out_hit, out_win, out_cfg and out_addr are registered and reflect the access presented one cycle earlier. A cycle with in_vld=0 gives out_vld=out_hit=out_cfg=0 in the next cycle.
- R11: A window in OPEN never hits. A miss reports out_vld=1, out_hit=0, out_cfg=0, out_win=0 and out_addr=0.
- R12: The write port selects a field with wr_fld: 0 = base, 1 = bound, 2 = offset, 3 = space (wr_data[1:0]), 4 = control (wr_data[0] = enable), 5 = configuration base (wr_win is ignored). wr_win picks the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Target window of the write |
| wr_fld | input | 3 | Field code of the write |
| wr_data | input | 32 | Write data |
| in_vld | input | 1 | Access strobe |
| in_addr | input | 32 | Incoming bus address |
| in_spc | input | 2 | Incoming address-space code |
| out_vld | output | 1 | Decode result valid |
| out_hit | output | 1 | A window claimed the access |
| out_win | output | 2 | Index of the claiming window |
| out_cfg | output | 1 | The configuration region claimed the access |
| out_addr | output | 32 | Translated local address |

## Verification
The main table sends accesses just inside and just outside each window edge. These separate page-granular compares from byte-exact compares, and inclusive base checks from exclusive bound checks. The same address is also sent in different space codes, which shows whether the space qualifier is applied per window and whether the configuration region is limited to 32-bit accesses. An offset that wraps past 2^32 shows whether the addition is truncated correctly. Directed sequences then use overlapping windows to expose the wrong priority order, and write to locked windows to show that frozen fields really stay unchanged.

// File: rtl/swx_pkg.sv
package swx_pkg;

    // address-space qualifier codes
    typedef enum logic [1:0] {
        SPC_A16 = 2'b00,
        SPC_A24 = 2'b01,
        SPC_A32 = 2'b10,
        SPC_RSV = 2'b11
    } spc_e;

    // write-port field selector codes
    typedef enum logic [2:0] {
        FLD_BASE  = 3'd0,
        FLD_BOUND = 3'd1,
        FLD_OFFS  = 3'd2,
        FLD_SPACE = 3'd3,
        FLD_CTRL  = 3'd4,
        FLD_CFGB  = 3'd5,
        FLD_NU6   = 3'd6,
        FLD_NU7   = 3'd7
    } fld_e;

    // per-window programming state
    typedef enum logic {
        WS_OPEN   = 1'b0,
        WS_LOCKED = 1'b1
    } win_st_e;

    // registered decode outcome
    typedef enum logic [1:0] {
        RES_MISS = 2'd0,
        RES_WIN  = 2'd1,
        RES_CFG  = 2'd2
    } res_e;

endpackage

// File: rtl/swx_win_slot.sv
module swx_win_slot
    import swx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 16,
    parameter int IDX_W     = 2,
    parameter int SLOT_ID   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_win,
    input  logic [2:0]        wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [1:0]        q_spc,
    output logic              hit,
    output logic [ADDR_W-1:0] xl_addr
);

    localparam int PAGE_W = ADDR_W - GRAN_BITS;

    win_st_e           st_q, st_d;
    logic [PAGE_W-1:0] base_pg, bound_pg;
    logic [ADDR_W-1:0] offs_q;
    spc_e              spc_q;
    logic              sel;
    fld_e              fld;
    logic [PAGE_W-1:0] q_pg;

    assign sel  = wr_en && (wr_win == IDX_W'(SLOT_ID));
    assign fld  = fld_e'(wr_fld);
    assign q_pg = q_addr[ADDR_W-1:GRAN_BITS];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_OPEN;
        else        st_q <= st_d;
    end

    // next-state: arm / disarm via control field
    always_comb begin
        st_d = st_q;
        if (sel && fld == FLD_CTRL) begin
            unique case (st_q)
                WS_OPEN:   if (wr_data[0])  st_d = WS_LOCKED;
                WS_LOCKED: if (!wr_data[0]) st_d = WS_OPEN;
            endcase
        end
    end

    // attribute fields, writable only while OPEN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_pg  <= '0;
            bound_pg <= '0;
            offs_q   <= '0;
            spc_q    <= SPC_RSV;
        end else if (sel && st_q == WS_OPEN) begin
            case (fld)
                FLD_BASE:  base_pg  <= wr_data[ADDR_W-1:GRAN_BITS];
                FLD_BOUND: bound_pg <= wr_data[ADDR_W-1:GRAN_BITS];
                FLD_OFFS:  offs_q   <= wr_data;
                FLD_SPACE: spc_q    <= spc_e'(wr_data[1:0]);
                default:   ;
            endcase
        end
    end

    // hit and translation outputs
    always_comb begin
        hit = (st_q == WS_LOCKED)
           && (spc_q != SPC_RSV)
           && (q_spc == spc_q)
           && (q_pg >= base_pg)
           && (q_pg < bound_pg);
        xl_addr = q_addr + offs_q;
    end

endmodule

// File: rtl/swx_cfg_dec.sv
module swx_cfg_dec
    import swx_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CFG_GRAN = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_fld,
    input  logic [ADDR_W-1:CFG_GRAN]   wr_page,
    input  logic [ADDR_W-1:0]          q_addr,
    input  logic [1:0]                 q_spc,
    output logic                       cfg_hit,
    output logic [ADDR_W-1:0]          cfg_addr
);

    logic [ADDR_W-1:CFG_GRAN] cfg_pg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     cfg_pg <= '0;
        else if (wr_en && fld_e'(wr_fld) == FLD_CFGB)   cfg_pg <= wr_page;
    end

    always_comb begin
        cfg_hit  = (spc_e'(q_spc) == SPC_A32) && (q_addr[ADDR_W-1:CFG_GRAN] == cfg_pg);
        cfg_addr = {{(ADDR_W-CFG_GRAN){1'b0}}, q_addr[CFG_GRAN-1:0]};
    end

endmodule

// File: rtl/swx_prio_sel.sv
module swx_prio_sel #(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2,
    parameter int ADDR_W  = 32
) (
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] addr_vec,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               sel_idx,
    output logic [ADDR_W-1:0]              sel_addr
);

    // scan from the top down so the lowest index is the last to win
    always_comb begin
        any_hit  = |hit_vec;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx  = IDX_W'(i);
                sel_addr = addr_vec[i];
            end
        end
    end

endmodule

// File: rtl/slv_win_xlate.sv
module slv_win_xlate
    import swx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_WIN    = 4,
    parameter int W0_GRAN    = 12,
    parameter int WN_GRAN    = 16,
    parameter int CFG_GRAN   = 12,
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_win,
    input  logic [2:0]        wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              in_vld,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_spc,
    output logic              out_vld,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_win,
    output logic              out_cfg,
    output logic [ADDR_W-1:0] out_addr
);

    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xl_vec;
    logic                           win_any;
    logic [IDX_W-1:0]               win_idx;
    logic [ADDR_W-1:0]              win_addr;
    logic                           cfg_hit;
    logic [ADDR_W-1:0]              cfg_addr;
    res_e                           res_d;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_slot
        localparam int GB = (g == 0) ? W0_GRAN : WN_GRAN;
        swx_win_slot #(
            .ADDR_W    (ADDR_W),
            .GRAN_BITS (GB),
            .IDX_W     (IDX_W),
            .SLOT_ID   (g)
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_win  (wr_win),
            .wr_fld  (wr_fld),
            .wr_data (wr_data),
            .q_addr  (in_addr),
            .q_spc   (in_spc),
            .hit     (hit_vec[g]),
            .xl_addr (xl_vec[g])
        );
    end

    swx_prio_sel #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W)
    ) prio_i (
        .hit_vec  (hit_vec),
        .addr_vec (xl_vec),
        .any_hit  (win_any),
        .sel_idx  (win_idx),
        .sel_addr (win_addr)
    );

    swx_cfg_dec #(
        .ADDR_W   (ADDR_W),
        .CFG_GRAN (CFG_GRAN)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_fld   (wr_fld),
        .wr_page  (wr_data[ADDR_W-1:CFG_GRAN]),
        .q_addr   (in_addr),
        .q_spc    (in_spc),
        .cfg_hit  (cfg_hit),
        .cfg_addr (cfg_addr)
    );

    // outcome select: configuration region first, then windows
    always_comb begin
        if (!in_vld)      res_d = RES_MISS;
        else if (cfg_hit) res_d = RES_CFG;
        else if (win_any) res_d = RES_WIN;
        else              res_d = RES_MISS;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_hit  <= 1'b0;
            out_win  <= '0;
            out_cfg  <= 1'b0;
            out_addr <= '0;
        end else begin
            out_vld <= in_vld;
            unique case (res_d)
                RES_CFG: begin
                    out_hit  <= 1'b0;
                    out_win  <= '0;
                    out_cfg  <= 1'b1;
                    out_addr <= cfg_addr;
                end
                RES_WIN: begin
                    out_hit  <= 1'b1;
                    out_win  <= win_idx;
                    out_cfg  <= 1'b0;
                    out_addr <= win_addr;
                end
                default: begin
                    out_hit  <= 1'b0;
                    out_win  <= '0;
                    out_cfg  <= 1'b0;
                    out_addr <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/slv_win_xlate_chk.sv
module slv_win_xlate_chk #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 2,
    parameter int CFG_GRAN = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [1:0]        in_spc,
    input logic              out_vld,
    input logic              out_hit,
    input logic [IDX_W-1:0]  out_win,
    input logic              out_cfg,
    input logic [ADDR_W-1:0] out_addr
);

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !out_hit && !out_cfg));

    // R8
    cfg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg |-> !out_hit);

    // R8
    cfg_a32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_spc != 2'b10) |=> !out_cfg);

    // R8
    cfg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg |-> (out_addr[ADDR_W-1:CFG_GRAN] == '0));

    // R4
    rsv_spc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_spc == 2'b11) |=> (!out_hit && !out_cfg));

    // R11
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_hit && !out_cfg) |-> (out_addr == '0 && out_win == '0));

endmodule

bind slv_win_xlate slv_win_xlate_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .CFG_GRAN (CFG_GRAN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_spc   (in_spc),
    .out_vld  (out_vld),
    .out_hit  (out_hit),
    .out_win  (out_win),
    .out_cfg  (out_cfg),
    .out_addr (out_addr)
);

// File: tb/slv_win_xlate_tb_top.sv
`timescale 1ns/1ps
module slv_win_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_win = '0;
    logic [2:0]  wr_fld = '0;
    logic [31:0] wr_data = '0;
    logic        in_vld = 1'b0;
    logic [31:0] in_addr = '0;
    logic [1:0]  in_spc = '0;
    logic        out_vld, out_hit, out_cfg;
    logic [1:0]  out_win;
    logic [31:0] out_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    slv_win_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_win(wr_win), .wr_fld(wr_fld), .wr_data(wr_data),
        .in_vld(in_vld), .in_addr(in_addr), .in_spc(in_spc),
        .out_vld(out_vld), .out_hit(out_hit), .out_win(out_win),
        .out_cfg(out_cfg), .out_addr(out_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  spc;
        logic        hit;
        logic [1:0]  win;
        logic        cfg;
        logic [31:0] xa;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1234, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0000_1234, 4'd6},  // R6
        '{32'h0009_FFFF, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0009_FFFF, 4'd2},  // R2
        '{32'h000A_0400, 2'd2, 1'b1, 2'd1, 1'b0, 32'h0010_0400, 4'd3},  // R3
        '{32'h003F_FFFC, 2'd2, 1'b1, 2'd1, 1'b0, 32'h0045_FFFC, 4'd5},  // R5
        '{32'h0040_0000, 2'd2, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'd5},  // R5
        '{32'h0030_0010, 2'd2, 1'b0, 2'd0, 1'b1, 32'h0000_0010, 4'd8},  // R8
        '{32'h0030_0010, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'd8},  // R8
        '{32'h0015_0000, 2'd1, 1'b1, 2'd2, 1'b0, 32'h0005_0000, 4'd6},  // R6
        '{32'h0015_0000, 2'd2, 1'b1, 2'd1, 1'b0, 32'h001B_0000, 4'd4},  // R4
        '{32'h0000_8000, 2'd0, 1'b1, 2'd3, 1'b0, 32'h8000_8000, 4'd4},  // R4
        '{32'h0000_8000, 2'd3, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'd4},  // R4
        '{32'h0000_8000, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 4'd4},  // R4
        '{32'h0031_0000, 2'd2, 1'b1, 2'd1, 1'b0, 32'h0037_0000, 4'd6}   // R6
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [2:0] f, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = w; wr_fld = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // present one access, then compare at the following falling edge
    task automatic acc(input string tag, input logic [31:0] a, input logic [1:0] s,
                       input logic eh, input logic [1:0] ew, input logic ec,
                       input logic [31:0] ea);
        @(negedge clk);
        in_vld = 1'b1; in_addr = a; in_spc = s;
        @(negedge clk);
        in_vld = 1'b0;
        chk(tag, "out_vld",  {31'd0, out_vld}, 32'd1);
        chk(tag, "out_hit",  {31'd0, out_hit}, {31'd0, eh});
        chk(tag, "out_win",  {30'd0, out_win}, {30'd0, ew});
        chk(tag, "out_cfg",  {31'd0, out_cfg}, {31'd0, ec});
        chk(tag, "out_addr", out_addr, ea);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "out_vld", {31'd0, out_vld}, 32'd0);
        chk("R1", "out_hit", {31'd0, out_hit}, 32'd0);
        chk("R1", "out_cfg", {31'd0, out_cfg}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: windows start OPEN, so nothing hits
        acc("R11", 32'h0000_5000, 2'd2, 1'b0, 2'd0, 1'b0, 32'h0);
        // R1: configuration base resets to 0
        acc("R1", 32'h0000_0010, 2'd2, 1'b0, 2'd0, 1'b1, 32'h10);

        // R12: program windows through the field codes
        wr(2'd0, 3'd0, 32'h0000_0FFF);   // base -> page 0 (R2)
        wr(2'd0, 3'd1, 32'h000A_0800);   // bound acts as 0xA0000 (R2)
        wr(2'd0, 3'd2, 32'h0000_0000);
        wr(2'd0, 3'd3, 32'h0000_0002);
        wr(2'd1, 3'd0, 32'h000A_8000);   // base acts as 0xA0000 (R3)
        wr(2'd1, 3'd1, 32'h0040_0000);
        wr(2'd1, 3'd2, 32'h0006_0000);
        wr(2'd1, 3'd3, 32'h0000_0002);
        wr(2'd2, 3'd0, 32'h0010_0000);
        wr(2'd2, 3'd1, 32'h0020_0000);
        wr(2'd2, 3'd2, 32'hFFF0_0000);
        wr(2'd2, 3'd3, 32'h0000_0001);
        wr(2'd3, 3'd0, 32'h0000_0000);
        wr(2'd3, 3'd1, 32'h0001_0000);
        wr(2'd3, 3'd2, 32'h8000_0000);
        wr(2'd3, 3'd3, 32'h0000_0000);
        wr(2'd3, 3'd5, 32'h0030_0ABC);   // configuration base (R8)
        for (int w = 0; w < 4; w++) wr(w[1:0], 3'd4, 32'h1);

        for (int i = 0; i < NV; i++) begin
            acc($sformatf("R%0d", VEC[i].req), VEC[i].addr, VEC[i].spc,
                VEC[i].hit, VEC[i].win, VEC[i].cfg, VEC[i].xa);
        end

        // R10: outputs go quiet one cycle after the strobe drops
        @(negedge clk);
        chk("R10", "out_vld idle", {31'd0, out_vld}, 32'd0);
        chk("R10", "out_hit idle", {31'd0, out_hit}, 32'd0);

        // R9: locked fields stay frozen
        wr(2'd0, 3'd0, 32'h0005_0000);
        wr(2'd0, 3'd2, 32'h1000_0000);
        acc("R9", 32'h0000_1234, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0000_1234);
        // R11: disarm, then window 0 no longer claims
        wr(2'd0, 3'd4, 32'h0);
        acc("R11", 32'h0000_1234, 2'd2, 1'b0, 2'd0, 1'b0, 32'h0);
        // R9: while OPEN the writes take effect
        wr(2'd0, 3'd0, 32'h0005_0000);
        wr(2'd0, 3'd4, 32'h1);
        acc("R9", 32'h0000_1234, 2'd2, 1'b0, 2'd0, 1'b0, 32'h0);
        acc("R9", 32'h0005_0000, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0005_0000);

        // R5: an empty window never hits
        wr(2'd2, 3'd4, 32'h0);
        wr(2'd2, 3'd1, 32'h0010_0000);
        wr(2'd2, 3'd4, 32'h1);
        acc("R5", 32'h0010_0000, 2'd1, 1'b0, 2'd0, 1'b0, 32'h0);

        // R7: overlap of windows 0 and 1, lowest index wins
        wr(2'd1, 3'd4, 32'h0);
        wr(2'd1, 3'd0, 32'h0008_0000);
        wr(2'd1, 3'd4, 32'h1);
        acc("R7", 32'h0008_5000, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0008_5000);
        acc("R7", 32'h000A_0000, 2'd2, 1'b1, 2'd1, 1'b0, 32'h0010_0000);

        // R8: configuration region overrides an overlapping window
        wr(2'd0, 3'd5, 32'h0008_5000);
        acc("R8", 32'h0008_5010, 2'd2, 1'b0, 2'd0, 1'b1, 32'h0000_0010);
        acc("R8", 32'h0008_6010, 2'd2, 1'b1, 2'd0, 1'b0, 32'h0008_6010);

        done = 1'b1;
        finish_run();
    end

endmodule